// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block gathers a vector of level-style device interrupt requests into one shared pending vector and routes it to several processors. Devices raise a request with a per-line set strobe and drop it with a per-line clear strobe. Each processor owns a mask register that selects which pending lines may interrupt it. The block drives one registered device-interrupt output per processor. That output is high whenever the processor's masked status is non-zero.

Software reaches the masks and the status through a single-cycle register port. The port takes a byte offset, a write enable and an access width flag (64-bit or 32-bit). Each register occupies its own 64-byte slot. Read data and the error flag arrive on the cycle after the access. An access that the map does not allow sets the error flag for one cycle, and any write data it carries is dropped.

Top module: `irq_router`

## Requirements
- R1: After reset the pending vector, every mask, every interrupt output, the read data and the error flag are zero.
- R2: A set strobe on line n makes bit n of the pending vector one at the next clock edge.
- R3: On the clock edge after any strobe or mask write, `cpu_irq[c]` equals the OR of all bits of (mask of CPU c AND pending vector).
- R4: A clear strobe on line n zeroes pending bit n at the next edge. A clear strobe on a line whose pending bit is already zero changes no register and no output.
- R5: When a set strobe and a clear strobe hit the same line in the same cycle, the set wins and the pending bit ends up one.
- R6: A mask write that enables a pending line raises that CPU's interrupt. A mask write that disables the last active line drops it. A mask write and a set strobe in the same cycle are both applied.
- R7: Reading the status register of CPU c returns (mask of CPU c AND pending vector).
- R8: Register index = offset >> 6. The map is: index 0 is control (reads 0); indices 1 to 4 are address-assignment slots (read 0); index 8+c is the mask of CPU c (read/write); index 12+c is the status of CPU c (read-only); index 16 is the pending vector (read-only). An offset with any of its low 6 bits set is an error.
- R9: A 32-bit read (`reg_wide`=0) of the pending vector returns its low 32 bits with the upper half zero, without error. Any other 32-bit access is an error.
- R10: A write to a read-only or zero slot, an access to an undefined index, or an illegal width raises `reg_err` for exactly one cycle. The write changes no register, and a read that errors returns zero.
- R11: Read data for an access presented in cycle t is on `reg_rdata` in cycle t+1 and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_set | input | NUM_LINES | Per-line request set strobes |
| line_clr | input | NUM_LINES | Per-line request clear strobes |
| reg_req | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | OFFS_W | Byte offset from block base |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Registered read data |
| reg_err | output | 1 | One-cycle access error flag |
| cpu_irq | output | NUM_CPU | Registered per-CPU device interrupt |

## Verification
Two pairs of functions can act in the same cycle. The first is a set strobe and a clear strobe on one line. The second is a mask write and a set strobe on the line that the write newly enables. Both are provoked by driving the two stimuli on the same falling edge. They are judged one cycle later: the pending vector must hold the line, and the affected CPU's interrupt must be high. A collision where a further line is only cleared shows that the set wins per line and does not mask the other clears.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_ZERO,
    RK_MASK,
    RK_STAT,
    RK_PEND
  } reg_kind_e;

  // Slot indices (byte offset >> 6)
  localparam int IDX_CTRL      = 0;
  localparam int IDX_ASSIGN_LO = 1;
  localparam int IDX_ASSIGN_HI = 4;
  localparam int IDX_MASK_BASE = 8;
  localparam int IDX_STAT_BASE = 12;
  localparam int IDX_PEND      = 16;
  localparam int SLOT_SHIFT    = 6;
endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 6,
  parameter int CPU_W   = 2
) (
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic             acc_wide,
  input  logic             acc_misalign,
  input  logic [IDX_W-1:0] acc_idx,
  output reg_kind_e        kind,
  output logic [CPU_W-1:0] cpu_sel,
  output logic             acc_err
);
  int idx_i;

  always_comb begin
    idx_i   = 32'(acc_idx);
    kind    = RK_NONE;
    cpu_sel = '0;
    if (idx_i == IDX_CTRL || (idx_i >= IDX_ASSIGN_LO && idx_i <= IDX_ASSIGN_HI)) begin
      kind = RK_ZERO;
    end else if (idx_i >= IDX_MASK_BASE && idx_i < IDX_MASK_BASE + NUM_CPU) begin
      kind    = RK_MASK;
      cpu_sel = CPU_W'(idx_i - IDX_MASK_BASE);
    end else if (idx_i >= IDX_STAT_BASE && idx_i < IDX_STAT_BASE + NUM_CPU) begin
      kind    = RK_STAT;
      cpu_sel = CPU_W'(idx_i - IDX_STAT_BASE);
    end else if (idx_i == IDX_PEND) begin
      kind = RK_PEND;
    end
  end

  always_comb begin
    acc_err = acc_en && (acc_misalign
                         || kind == RK_NONE
                         || (acc_we && kind != RK_MASK)
                         || (!acc_wide && (acc_we || kind != RK_PEND)));
  end
endmodule

// File: rtl/irq_router_pend.sv
module irq_router_pend #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_set,
  input  logic [NUM_LINES-1:0] line_clr,
  output logic [NUM_LINES-1:0] pend_nxt,
  output logic [NUM_LINES-1:0] pend_q
);
  // Set dominates clear on the same line; clearing a zero bit is a no-op.
  always_comb pend_nxt = line_set | (pend_q & ~line_clr);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end
endmodule

// File: rtl/irq_router_cpu.sv
module irq_router_cpu #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  input  logic [NUM_LINES-1:0] pend_q,
  input  logic [NUM_LINES-1:0] pend_nxt,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] status,
  output logic                 irq_q
);
  logic [NUM_LINES-1:0] mask_nxt;

  always_comb mask_nxt = wr_en ? wr_data : mask_q;
  always_comb status   = mask_q & pend_q;

  // Output computed from next-state values so it lands one edge after the cause.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      irq_q  <= |(mask_nxt & pend_nxt);
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64,
  parameter int OFFS_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_set,
  input  logic [NUM_LINES-1:0] line_clr,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic                 reg_wide,
  input  logic [OFFS_W-1:0]    reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic                 reg_err,
  output logic [NUM_CPU-1:0]   cpu_irq
);
  localparam int IDX_W = OFFS_W - SLOT_SHIFT;
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int HALF  = NUM_LINES / 2;

  logic [NUM_LINES-1:0]         pend_q, pend_nxt;
  logic [NUM_LINES-1:0]         mask_arr [NUM_CPU];
  logic [NUM_LINES-1:0]         stat_arr [NUM_CPU];
  logic [NUM_CPU*NUM_LINES-1:0] mask_flat;
  reg_kind_e                    kind;
  logic [CPU_W-1:0]             cpu_sel;
  logic                         acc_err;
  logic [NUM_LINES-1:0]         rd_val;

  irq_router_decode #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .CPU_W(CPU_W)) u_dec (
    .acc_en      (reg_req),
    .acc_we      (reg_we),
    .acc_wide    (reg_wide),
    .acc_misalign(|reg_addr[SLOT_SHIFT-1:0]),
    .acc_idx     (reg_addr[OFFS_W-1:SLOT_SHIFT]),
    .kind        (kind),
    .cpu_sel     (cpu_sel),
    .acc_err     (acc_err)
  );

  irq_router_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .line_set(line_set),
    .line_clr(line_clr),
    .pend_nxt(pend_nxt),
    .pend_q  (pend_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic wr_hit;
    assign wr_hit = reg_req && reg_we && !acc_err && kind == RK_MASK
                    && cpu_sel == CPU_W'(c);
    irq_router_cpu #(.NUM_LINES(NUM_LINES)) u_cpu (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_hit),
      .wr_data (reg_wdata),
      .pend_q  (pend_q),
      .pend_nxt(pend_nxt),
      .mask_q  (mask_arr[c]),
      .status  (stat_arr[c]),
      .irq_q   (cpu_irq[c])
    );
    assign mask_flat[c*NUM_LINES +: NUM_LINES] = mask_arr[c];
  end

  always_comb begin
    case (kind)
      RK_MASK: rd_val = mask_arr[cpu_sel];
      RK_STAT: rd_val = stat_arr[cpu_sel];
      RK_PEND: rd_val = reg_wide ? pend_q : {{(NUM_LINES-HALF){1'b0}}, pend_q[HALF-1:0]};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_err <= acc_err;
      if (reg_req && !reg_we) reg_rdata <= acc_err ? '0 : rd_val;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_LINES-1:0]         line_set,
  input logic [NUM_LINES-1:0]         line_clr,
  input logic [NUM_LINES-1:0]         pend,
  input logic [NUM_CPU*NUM_LINES-1:0] mask_flat,
  input logic [NUM_CPU-1:0]           cpu_irq,
  input logic                         reg_req,
  input logic                         reg_err
);
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|line_set) |=> ((pend & $past(line_set)) == $past(line_set))); // R5

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(line_clr & ~line_set)) |=> ((pend & $past(line_clr & ~line_set)) == '0)); // R4

  AST_ERR_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> (mask_flat == $past(mask_flat))); // R10

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !reg_req |=> !reg_err); // R10

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      cpu_irq[c] == |(mask_flat[c*NUM_LINES +: NUM_LINES] & pend)); // R3
  end
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .line_set (line_set),
  .line_clr (line_clr),
  .pend     (pend_q),
  .mask_flat(mask_flat),
  .cpu_irq  (cpu_irq),
  .reg_req  (reg_req),
  .reg_err  (reg_err)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int NC = 4;
  localparam int NL = 64;
  localparam int OW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic [NL-1:0] line_set, line_clr, reg_wdata, reg_rdata;
  logic          reg_req, reg_we, reg_wide, reg_err;
  logic [OW-1:0] reg_addr;
  logic [NC-1:0] cpu_irq;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  irq_router #(.NUM_CPU(NC), .NUM_LINES(NL), .OFFS_W(OW)) u_irq_router (
    .clk(clk), .rst(rst), .line_set(line_set), .line_clr(line_clr),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wide(reg_wide), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err), .cpu_irq(cpu_irq)
  );

  function automatic logic [OW-1:0] mask_at(int c); return OW'(12'h200 + c * 64); endfunction
  function automatic logic [OW-1:0] stat_at(int c); return OW'(12'h300 + c * 64); endfunction
  localparam logic [OW-1:0] PEND_AT = 12'h400;

  task automatic check(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    line_set = '0; line_clr = '0; reg_req = 0; reg_we = 0; reg_wide = 1;
    reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic strobe(logic [NL-1:0] s, logic [NL-1:0] c);
    @(negedge clk); line_set = s; line_clr = c;
    @(posedge clk); @(negedge clk); line_set = '0; line_clr = '0;
  endtask

  task automatic wr(logic [OW-1:0] a, logic [NL-1:0] d, logic w, output logic e);
    @(negedge clk); reg_req = 1; reg_we = 1; reg_wide = w; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); e = reg_err; idle();
  endtask

  task automatic rd(logic [OW-1:0] a, logic w, output logic [NL-1:0] d, output logic e);
    @(negedge clk); reg_req = 1; reg_we = 0; reg_wide = w; reg_addr = a;
    @(posedge clk); @(negedge clk); d = reg_rdata; e = reg_err; idle();
  endtask

  task automatic t_reset();
    logic [NL-1:0] d; logic e;
    check("R1 irq", NL'(cpu_irq), '0);
    check("R1 err", NL'(reg_err), '0);
    check("R1 rdata", reg_rdata, '0);
    rd(PEND_AT, 1, d, e); check("R1 pend", d, '0);
    rd(mask_at(2), 1, d, e); check("R1 mask2", d, '0);
  endtask

  task automatic t_route();
    logic [NL-1:0] d; logic e;
    wr(mask_at(0), 64'h1, 1, e);
    wr(mask_at(1), (64'h1 << 63) | 64'h20, 1, e);
    wr(mask_at(2), '1, 1, e);
    check("R6 no irq before request", NL'(cpu_irq), '0);
    strobe(64'h20, '0);
    check("R3 irq after set line5", NL'(cpu_irq), NL'(4'b0110));
    rd(PEND_AT, 1, d, e); check("R2 pend line5", d, 64'h20);
    rd(stat_at(1), 1, d, e); check("R7 status cpu1", d, 64'h20);
    rd(stat_at(0), 1, d, e); check("R7 status cpu0", d, '0);
    rd(mask_at(1), 1, d, e); check("R8 mask1 readback", d, (64'h1 << 63) | 64'h20);
  endtask

  task automatic t_clear();
    logic [NL-1:0] d; logic e;
    strobe('0, 64'h20);
    check("R4 irq after clear", NL'(cpu_irq), '0);
    rd(PEND_AT, 1, d, e); check("R4 pend cleared", d, '0);
    strobe(64'h1 << 63, '0);
    strobe('0, 64'h200);
    check("R4 spurious clear irq", NL'(cpu_irq), NL'(4'b0110));
    rd(PEND_AT, 1, d, e); check("R4 spurious clear pend", d, 64'h1 << 63);
  endtask

  task automatic t_collide();
    logic [NL-1:0] d; logic e;
    strobe(64'h1, 64'h1 | (64'h1 << 63));
    check("R5 set wins irq", NL'(cpu_irq), NL'(4'b0101));
    rd(PEND_AT, 1, d, e); check("R5 set wins pend", d, 64'h1);
  endtask

  task automatic t_mask();
    logic e;
    wr(mask_at(3), 64'h1, 1, e);
    check("R6 enable raises cpu3", NL'(cpu_irq), NL'(4'b1101));
    wr(mask_at(0), '0, 1, e);
    check("R6 disable drops cpu0", NL'(cpu_irq), NL'(4'b1100));
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_wide = 1; reg_addr = mask_at(0);
    reg_wdata = 64'h80; line_set = 64'h80;
    @(posedge clk); @(negedge clk); idle();
    check("R6 write with set same cycle", NL'(cpu_irq), NL'(4'b1101));
  endtask

  task automatic t_narrow();
    logic [NL-1:0] d; logic e;
    strobe(64'h1 << 40, '0);
    rd(PEND_AT, 0, d, e);
    check("R9 narrow pend data", d, 64'h81);
    check("R9 narrow pend err", NL'(e), '0);
    rd(PEND_AT, 1, d, e); check("R11 wide pend data", d, (64'h1 << 40) | 64'h81);
    rd(mask_at(0), 0, d, e);
    check("R9 narrow mask err", NL'(e), 64'h1);
    check("R10 errored read zero", d, '0);
  endtask

  task automatic t_errors();
    logic [NL-1:0] d; logic e;
    wr(PEND_AT, '1, 1, e); check("R10 write pend err", NL'(e), 64'h1);
    rd(PEND_AT, 1, d, e); check("R10 pend untouched", d, (64'h1 << 40) | 64'h81);
    wr(stat_at(1), '1, 1, e); check("R10 write status err", NL'(e), 64'h1);
    wr(OW'(12'h180), '1, 1, e); check("R10 undefined write err", NL'(e), 64'h1);
    wr(mask_at(1), '1, 0, e); check("R9 narrow write err", NL'(e), 64'h1);
    rd(mask_at(1), 1, d, e); check("R10 mask1 untouched", d, (64'h1 << 63) | 64'h20);
    check("R10 err one cycle", NL'(reg_err), '0);
    rd(OW'(12'h208), 1, d, e); check("R8 misaligned err", NL'(e), 64'h1);
    rd(OW'(12'h000), 1, d, e); check("R8 control reads zero", d, '0);
    check("R8 control no err", NL'(e), '0);
    rd(OW'(12'h0c0), 1, d, e); check("R8 assign slot zero", d, '0);
    check("R11 rdata held", reg_rdata, '0);
  endtask

  initial begin
    idle(); rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_route();
    t_clear();
    t_collide();
    t_mask();
    t_narrow();
    t_errors();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(8 * 20000);
    misses++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule